// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block watches the read traffic of an asynchronous, SRAM-style bus. It looks for one fixed series of ordinary read addresses that stands for a command. Five lead addresses must be read in a fixed order. The sixth read then chooses the command: one terminating address asks for a nonvolatile save and another asks for a restore. The reads that make up the series stay ordinary reads. The array answers them as usual, and the detector only observes them.

Each bus input passes through a synchronous sampler first. A read is counted whether its access window was opened by the select strobe or by the read strobe. When the sixth address matches, the detector raises a one-cycle request toward the downstream sequencer. At the same time it raises a bus-disable level that keeps the data pins in high impedance. That level holds until the sequencer reports completion. While the sequencer reports that it is busy, no new command is accepted.

Top module: `nvc_cmd_detect`

## Requirements
- R1: After reset, and after a reset applied partway through a series, the detector is at its idle step and `store_req`, `recall_req` and `bus_hiz` are low. A terminating read that follows a reset produces no request.
- R2: Five lead reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F and 0x703F, in that order, followed by a read at 0x8FC0, give exactly one `store_req` pulse that is one cycle wide and no `recall_req`. The pulse is high from the third rising edge after the sixth read first becomes visible on the pins.
- R3: The same five lead reads followed by a read at 0x4C63 give exactly one one-cycle `recall_req` pulse and no `store_req`.
- R4: A read is active when `bus_sel_n`=0, `bus_rd_n`=0 and `bus_wr_n`=1. A read counts whether `bus_sel_n` or `bus_rd_n` was the last strobe to go low, and a single series may mix both styles.
- R5: A read at an address other than the one expected next returns the detector to idle. If that read is at 0x4E38, the series restarts at step one.
- R6: A write cycle (`bus_sel_n`=0 with `bus_wr_n`=0) at any step returns the detector to idle.
- R7: A read is counted only once its address has been equal on two consecutive sampling edges. An address held for many cycles within one select-low period counts once. An address present for a single edge is not counted.
- R8: `bus_hiz` rises together with the request pulse. It stays high until `op_done` is sampled high and falls on the following edge.
- R9: While `op_busy` is high, or while `bus_hiz` is high, reads are not matched and the detector is held at idle, so a full series gives no request.
- R10: A sixth read at an address that is neither terminator returns the detector to idle with no request. Addresses are compared over the full bus width, so any upper bit that is set prevents a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_n | input | 1 | Bus chip select, active low |
| bus_rd_n | input | 1 | Bus output enable, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_addr | input | ADDR_W (20) | Bus word address |
| op_busy | input | 1 | Sequencer is busy; new series are ignored |
| op_done | input | 1 | Sequencer finished the requested operation |
| store_req | output | 1 | One-cycle save request |
| recall_req | output | 1 | One-cycle restore request |
| bus_hiz | output | 1 | Keep the data bus in high impedance |

## Verification
Each read reaches the outputs through three registers: the pin sampler, the stability stage and the request register. The request pulse and the rise of `bus_hiz` are therefore due after the third rising edge that follows the pins showing the sixth read. The bench drives inputs just after a falling edge and samples just after later falling edges. The latency scenario checks that both outputs are still low after two edges, high after three and, for the pulse, low again after four. `op_done` passes through a single register, so `bus_hiz` is checked low one edge after `op_done` is raised. The other scenarios hold every read open long enough for its count to land, then compare pulse counters that advance on falling edges.

// File: rtl/nvc_pkg.sv
package nvc_pkg;

    localparam int KEY_W    = 16;
    localparam int NUM_LEAD = 5;
    localparam int STEP_W   = $clog2(NUM_LEAD + 1);

    localparam logic [KEY_W-1:0] KEY_SAVE    = 16'h8FC0;
    localparam logic [KEY_W-1:0] KEY_RESTORE = 16'h4C63;

    typedef enum logic [1:0] {
        HIT_NONE    = 2'd0,
        HIT_SAVE    = 2'd1,
        HIT_RESTORE = 2'd2
    } hit_e;

    function automatic logic [KEY_W-1:0] lead_key(input logic [STEP_W-1:0] idx);
        case (idx)
            3'd0:    lead_key = 16'h4E38;
            3'd1:    lead_key = 16'hB1C7;
            3'd2:    lead_key = 16'h83E0;
            3'd3:    lead_key = 16'h7C1F;
            3'd4:    lead_key = 16'h703F;
            default: lead_key = '0;
        endcase
    endfunction

endpackage

// File: rtl/nvc_bus_sampler.sv
module nvc_bus_sampler #(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              rd_evt,
    output logic [ADDR_W-1:0] evt_addr,
    output logic              wr_seen
);

    typedef struct packed {
        logic              sel_n1;
        logic              rd_n1;
        logic              wr_n1;
        logic [ADDR_W-1:0] addr1;
        logic              rd2;
        logic [ADDR_W-1:0] addr2;
        logic              armed;
    } smp_t;

    smp_t q, d;
    logic rd1, stable;

    always_comb begin
        d        = q;
        rd1      = !q.sel_n1 && !q.rd_n1 && q.wr_n1;
        stable   = (q.addr1 == q.addr2);
        rd_evt   = rd1 && q.rd2 && stable && q.armed;
        evt_addr = q.addr1;
        wr_seen  = !q.sel_n1 && !q.wr_n1;

        d.sel_n1 = bus_sel_n;
        d.rd_n1  = bus_rd_n;
        d.wr_n1  = bus_wr_n;
        d.addr1  = bus_addr;
        d.rd2    = rd1;
        d.addr2  = q.addr1;

        if (!rd1 || !stable) begin
            d.armed = 1'b1;
        end else if (rd_evt) begin
            d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.sel_n1 <= 1'b1;
            q.rd_n1  <= 1'b1;
            q.wr_n1  <= 1'b1;
            q.addr1  <= '0;
            q.rd2    <= 1'b0;
            q.addr2  <= '0;
            q.armed  <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nvc_seq_matcher.sv
module nvc_seq_matcher
    import nvc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic              wr_seen,
    input  logic              blocked,
    output hit_e              hit
);

    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_LEAD);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } mt_t;

    mt_t q, d;
    logic is_first;

    always_comb begin
        d        = q;
        hit      = HIT_NONE;
        is_first = (evt_addr == ADDR_W'(lead_key('0)));

        if (blocked || wr_seen) begin
            d.step = '0;
        end else if (rd_evt) begin
            if (q.step == LAST_STEP) begin
                if (evt_addr == ADDR_W'(KEY_SAVE)) begin
                    hit    = HIT_SAVE;
                    d.step = '0;
                end else if (evt_addr == ADDR_W'(KEY_RESTORE)) begin
                    hit    = HIT_RESTORE;
                    d.step = '0;
                end else begin
                    d.step = is_first ? STEP_W'(1) : '0;
                end
            end else if (evt_addr == ADDR_W'(lead_key(q.step))) begin
                d.step = q.step + STEP_W'(1);
            end else begin
                d.step = is_first ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.step <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nvc_req_ctrl.sv
module nvc_req_ctrl
    import nvc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  hit_e hit,
    input  logic op_done,
    output logic store_req,
    output logic recall_req,
    output logic bus_hiz
);

    typedef struct packed {
        logic save;
        logic restore;
        logic pend;
    } rq_t;

    rq_t q, d;

    always_comb begin
        d         = q;
        d.save    = (hit == HIT_SAVE);
        d.restore = (hit == HIT_RESTORE);
        if (hit != HIT_NONE) begin
            d.pend = 1'b1;
        end else if (op_done) begin
            d.pend = 1'b0;
        end
        store_req  = q.save;
        recall_req = q.restore;
        bus_hiz    = q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nvc_cmd_detect.sv
module nvc_cmd_detect
    import nvc_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              op_busy,
    input  logic              op_done,
    output logic              store_req,
    output logic              recall_req,
    output logic              bus_hiz
);

    logic              rd_evt;
    logic              wr_seen;
    logic [ADDR_W-1:0] evt_addr;
    logic              blocked;
    hit_e              hit;

    assign blocked = op_busy || bus_hiz;

    nvc_bus_sampler #(.ADDR_W(ADDR_W)) u_smp (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel_n (bus_sel_n),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_addr  (bus_addr),
        .rd_evt    (rd_evt),
        .evt_addr  (evt_addr),
        .wr_seen   (wr_seen)
    );

    nvc_seq_matcher #(.ADDR_W(ADDR_W)) u_mat (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_evt   (rd_evt),
        .evt_addr (evt_addr),
        .wr_seen  (wr_seen),
        .blocked  (blocked),
        .hit      (hit)
    );

    nvc_req_ctrl u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .op_done    (op_done),
        .store_req  (store_req),
        .recall_req (recall_req),
        .bus_hiz    (bus_hiz)
    );

endmodule

// File: rtl/nvc_cmd_detect_chk.sv
module nvc_cmd_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic op_done,
    input logic store_req,
    input logic recall_req,
    input logic bus_hiz
);

    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req)); // R2

    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R2

    AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R3

    AST_HIZ_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (store_req || recall_req) |-> bus_hiz); // R8

    AST_HIZ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_hiz) |-> (store_req || recall_req)); // R8

    AST_HIZ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hiz && !op_done) |=> bus_hiz); // R8

    AST_HIZ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_hiz && op_done) |=> !bus_hiz); // R8

    AST_NO_REQ_WHILE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hiz |=> !(store_req || recall_req)); // R9

endmodule

bind nvc_cmd_detect nvc_cmd_detect_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_done    (op_done),
    .store_req  (store_req),
    .recall_req (recall_req),
    .bus_hiz    (bus_hiz)
);

// File: tb/nvc_cmd_detect_tb.sv
module nvc_cmd_detect_tb;
    import nvc_pkg::*;

    localparam int AW = 20;
    localparam logic [AW-1:0] A_SAVE    = AW'(KEY_SAVE);
    localparam logic [AW-1:0] A_RESTORE = AW'(KEY_RESTORE);

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          bus_sel_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          op_busy = 1'b0, op_done = 1'b0;
    logic          store_req, recall_req, bus_hiz;

    int n_chk = 0, n_fail = 0, n_store = 0, n_recall = 0;
    bit finished = 1'b0;

    nvc_cmd_detect #(.ADDR_W(AW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel_n  (bus_sel_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_addr   (bus_addr),
        .op_busy    (op_busy),
        .op_done    (op_done),
        .store_req  (store_req),
        .recall_req (recall_req),
        .bus_hiz    (bus_hiz)
    );

    always @(negedge clk) begin
        if (store_req)  n_store++;
        if (recall_req) n_recall++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] lead(input int i);
        return AW'(lead_key(STEP_W'(i)));
    endfunction

    // oe_ctl=0: select strobe falls last; oe_ctl=1: read strobe falls last
    task automatic rd(input logic [AW-1:0] a, input bit oe_ctl);
        bus_addr = a;
        bus_wr_n = 1'b1;
        if (oe_ctl) begin
            bus_sel_n = 1'b0; tick(1); bus_rd_n = 1'b0;
        end else begin
            bus_rd_n = 1'b0; tick(1); bus_sel_n = 1'b0;
        end
        tick(3);
        bus_sel_n = 1'b1;
        bus_rd_n  = 1'b1;
        tick(2);
    endtask

    task automatic lead_reads(input bit mode);
        for (int i = 0; i < NUM_LEAD; i++) rd(lead(i), mode);
    endtask

    task automatic finish_op();
        op_done = 1'b1; tick(1);
        op_done = 1'b0; tick(1);
    endtask

    task automatic t_reset();
        int s0;
        chk("R1 store_req in reset", store_req, 0);
        chk("R1 recall_req in reset", recall_req, 0);
        chk("R1 bus_hiz in reset", bus_hiz, 0);
        rst_n = 1'b1; tick(2);
        s0 = n_store;
        lead_reads(1'b0);
        rst_n = 1'b0; tick(2);
        chk("R1 outputs low during mid-series reset", store_req | recall_req | bus_hiz, 0);
        rst_n = 1'b1; tick(2);
        rd(A_SAVE, 1'b0);
        chk("R1 no request after reset mid-series", n_store - s0, 0);
        chk("R1 bus_hiz low after reset mid-series", bus_hiz, 0);
    endtask

    task automatic t_store_latency();
        int s0, r0;
        s0 = n_store; r0 = n_recall;
        lead_reads(1'b0);
        bus_addr = A_SAVE; bus_rd_n = 1'b0; bus_sel_n = 1'b0;
        tick(2);
        chk("R2 store_req low after two edges", store_req, 0);
        chk("R8 bus_hiz low after two edges", bus_hiz, 0);
        tick(1);
        chk("R2 store_req high after three edges", store_req, 1);
        chk("R8 bus_hiz rises with request", bus_hiz, 1);
        tick(1);
        chk("R2 store_req one cycle wide", store_req, 0);
        bus_sel_n = 1'b1; bus_rd_n = 1'b1;
        tick(5);
        chk("R8 bus_hiz held until done", bus_hiz, 1);
        chk("R2 exactly one store pulse", n_store - s0, 1);
        chk("R2 no recall pulse", n_recall - r0, 0);
        op_done = 1'b1; tick(1);
        chk("R8 bus_hiz falls one edge after done", bus_hiz, 0);
        op_done = 1'b0; tick(1);
    endtask

    task automatic t_recall_oe();
        int s0, r0;
        s0 = n_store; r0 = n_recall;
        lead_reads(1'b1);
        rd(A_RESTORE, 1'b1);
        chk("R3 R4 one recall pulse with read-strobe reads", n_recall - r0, 1);
        chk("R3 no store pulse", n_store - s0, 0);
        chk("R8 bus_hiz high after recall", bus_hiz, 1);
        finish_op();
        chk("R8 bus_hiz low after done", bus_hiz, 0);
    endtask

    task automatic t_mixed();
        int s0;
        s0 = n_store;
        for (int i = 0; i < NUM_LEAD; i++) rd(lead(i), i[0]);
        rd(A_SAVE, 1'b1);
        chk("R4 mixed strobe styles complete a series", n_store - s0, 1);
        finish_op();
    endtask

    task automatic t_wrong_addr();
        int s0;
        s0 = n_store;
        rd(lead(0), 1'b0); rd(lead(1), 1'b0); rd(AW'(20'h01111), 1'b0);
        for (int i = 2; i < NUM_LEAD; i++) rd(lead(i), 1'b0);
        rd(A_SAVE, 1'b0);
        chk("R5 wrong address aborts series", n_store - s0, 0);
        chk("R5 bus_hiz stays low", bus_hiz, 0);
        rd(lead(0), 1'b0); rd(lead(1), 1'b0); rd(lead(0), 1'b0);
        for (int i = 1; i < NUM_LEAD; i++) rd(lead(i), 1'b0);
        rd(A_SAVE, 1'b0);
        chk("R5 first key restarts at step one", n_store - s0, 1);
        finish_op();
    endtask

    task automatic t_write();
        int s0;
        s0 = n_store;
        for (int i = 0; i < 3; i++) rd(lead(i), 1'b0);
        bus_addr = lead(3); bus_sel_n = 1'b0; bus_wr_n = 1'b0;
        tick(2);
        bus_sel_n = 1'b1; bus_wr_n = 1'b1;
        tick(2);
        rd(lead(3), 1'b0); rd(lead(4), 1'b0); rd(A_SAVE, 1'b0);
        chk("R6 write cycle aborts series", n_store - s0, 0);
    endtask

    task automatic t_sixth_other();
        int s0, r0;
        s0 = n_store; r0 = n_recall;
        lead_reads(1'b0);
        rd(AW'(20'h00000), 1'b0);
        rd(A_SAVE, 1'b0);
        chk("R10 unknown sixth address gives no store", n_store - s0, 0);
        chk("R10 unknown sixth address gives no recall", n_recall - r0, 0);
        lead_reads(1'b0);
        rd(A_SAVE | AW'(20'h10000), 1'b0);
        chk("R10 upper address bit blocks match", n_store - s0, 0);
    endtask

    task automatic t_hold_glitch();
        int s0;
        s0 = n_store;
        bus_wr_n = 1'b1; bus_rd_n = 1'b0; bus_addr = lead(0);
        bus_sel_n = 1'b0;
        tick(3);
        bus_addr = lead(1);      tick(10);
        bus_addr = AW'(20'h01234); tick(1);
        bus_addr = lead(2);      tick(3);
        bus_addr = lead(3);      tick(3);
        bus_addr = lead(4);      tick(3);
        bus_addr = A_SAVE;       tick(3);
        bus_sel_n = 1'b1; bus_rd_n = 1'b1;
        tick(2);
        chk("R7 held address counted once, one-edge address ignored", n_store - s0, 1);
        finish_op();
    endtask

    task automatic t_busy();
        int s0, r0;
        s0 = n_store; r0 = n_recall;
        op_busy = 1'b1;
        lead_reads(1'b0); rd(A_SAVE, 1'b0);
        op_busy = 1'b0; tick(1);
        chk("R9 series ignored while busy", n_store - s0, 0);
        for (int i = 0; i < 3; i++) rd(lead(i), 1'b0);
        op_busy = 1'b1; tick(2); op_busy = 1'b0; tick(1);
        rd(lead(3), 1'b0); rd(lead(4), 1'b0); rd(A_SAVE, 1'b0);
        chk("R9 busy mid-series returns to idle", n_store - s0, 0);
        lead_reads(1'b0); rd(A_SAVE, 1'b0);
        chk("R9 store accepted when not busy", n_store - s0, 1);
        lead_reads(1'b0); rd(A_RESTORE, 1'b0);
        chk("R9 no recall while operation pending", n_recall - r0, 0);
        chk("R8 bus_hiz still high while pending", bus_hiz, 1);
        finish_op();
        chk("R8 bus_hiz released", bus_hiz, 0);
    endtask

    initial begin
        tick(3);
        t_reset();
        t_store_latency();
        t_recall_oe();
        t_mixed();
        t_wrong_addr();
        t_write();
        t_sixth_other();
        t_hold_glitch();
        t_busy();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule